// File: doc/BRIEF.md
# Dual-Bank Serial LED Channel Driver

This block is the digital core of a 24-channel constant-current LED driver, seen from its serial control pins and run from a system clock. The channels form eight columns of three colours. A host shifts data in one bit at a time on a serial data pin, strobed by a serial clock pin. A bank-select pin, sampled on every serial clock edge, steers each bit into one of two shift chains. The first chain holds a 6-bit correction factor per channel. The second holds an 8-bit brightness value per channel.

A falling edge on the active-low load strobe multiplies each channel's two factors into a 14-bit intensity and stores it. A run pin (high) and a blank pin (low) must both be in the enabling state for the stored intensities to reach the outputs. Otherwise every output is zero. Each channel's intensity is turned into a pulse-width-modulated output by comparing it against a shared 14-bit free-running counter. A serial output passes on the bit that falls off the end of the selected chain, so that several devices can be cascaded.

Within each column, the first channel is blue, the second is green and the third is red. All six control pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and edges are detected on the synchronized levels.

Top module: `dualbank_led_drv`

## Requirements
- R1: The correction chain is 144 bits long, and channel n uses bits 6n+5..6n of it. The brightness chain is 192 bits long, and channel n uses bits 8n+7..8n of it. A bit shifted in first ends at the highest index once the chain is full.
- R2: On each synchronized rising edge of the serial clock, the data level enters bit 0 of the selected chain and every other bit of that chain moves up one place. The chain that is not selected is unchanged.
- R3: On the same serial clock edge, the serial output takes the bit that is about to leave the selected chain: bit 143 for bank-select low, or bit 191 for bank-select high. It holds that value until the next serial clock edge.
- R4: A synchronized falling edge of the load strobe stores, for every channel, its correction value times its brightness value as a 14-bit intensity. A rising edge of the strobe stores nothing.
- R5: A channel's output value equals its stored intensity while run is high and blank is low. In every other combination of the two pins, all output values are zero.
- R6: The output values are recomputed only when run changes, when blank changes, or in the cycle after a store. At all other times they hold.
- R7: Reset forces every PWM output low and all output values to zero. It keeps both chains and the stored intensities, and it sets the remembered load-strobe level high.
- R8: Each PWM output is high while the 14-bit counter is below that channel's output value. Over any 16384 consecutive cycles, the output is high for exactly that many cycles: never for value 0, and 16065 times for 63×255.
- R9: The bank choice is made anew on every serial clock edge, so bits for the two chains may be interleaved freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data bit, asynchronous |
| ser_clk_i | input | 1 | Serial shift clock, active on rising edge, asynchronous |
| bank_sel_i | input | 1 | Chain select: 0 correction, 1 brightness |
| load_n_i | input | 1 | Store strobe, active on falling edge |
| drv_run_i | input | 1 | High lets stored intensities reach the outputs |
| blank_i | input | 1 | High forces all outputs to zero |
| ser_out_o | output | 1 | Cascade bit leaving the selected chain |
| pwm_o | output | 24 | Per-channel PWM outputs |

## Verification
The bench fills the chains three times: with a zero brightness, with full-scale factors, and with ramps whose bits alternate between banks. It counts high cycles over whole counter periods. A design that confused the chain offsets, misjudged the 16065 ceiling, or let bank selection stick across an interleaved load would show the wrong duty on one or more channels. It then pulses reset and expects the stored intensities to return without a new store, and it expects the cascade bits to still come from the pre-reset chain contents. A design that cleared either would give zero duties or wrong serial bits. Finally it raises the strobe over changed chain contents and expects the old intensities, catching a store made on the wrong edge.

// File: rtl/dbl_pkg.sv
`timescale 1ns/1ps
package dbl_pkg;
  // synchronized pin vector layout
  localparam int PIN_DATA  = 0;
  localparam int PIN_BSEL  = 1;
  localparam int PIN_SCLK  = 2;
  localparam int PIN_LOAD  = 3;
  localparam int PIN_RUN   = 4;
  localparam int PIN_BLANK = 5;
  localparam int PIN_CNT   = 6;
  // pins from EDGE_BASE upward get edge tracking
  localparam int EDGE_BASE = PIN_SCLK;
  localparam int EDGE_CNT  = PIN_CNT - EDGE_BASE;
  localparam int EG_SCLK   = PIN_SCLK  - EDGE_BASE;
  localparam int EG_LOAD   = PIN_LOAD  - EDGE_BASE;
  localparam int EG_RUN    = PIN_RUN   - EDGE_BASE;
  localparam int EG_BLANK  = PIN_BLANK - EDGE_BASE;
  // reset levels: load strobe idles high so its first fall is seen
  localparam logic [PIN_CNT-1:0] PIN_RST = 6'b001000;
endpackage

// File: rtl/dbl_sync_stage.sv
`timescale 1ns/1ps
module dbl_sync_stage #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o
);
  logic [STAGES-1:0][W-1:0] st_q, st_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign st_d[s] = async_i;
      end else begin : g_next
        assign st_d[s] = st_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= st_d;
  end

  assign lvl_o = st_q[STAGES-1];
endmodule

// File: rtl/dbl_edge_track.sv
`timescale 1ns/1ps
module dbl_edge_track #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/dbl_shift_chain.sv
`timescale 1ns/1ps
module dbl_shift_chain #(
  parameter int LEN = 144
) (
  input  logic           clk,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] q_o,
  output logic           top_o
);
  logic [LEN-1:0] chain_q, chain_d;

  // contents survive reset by design: no reset term
  always_comb begin
    chain_d = {chain_q[LEN-2:0], din};
  end

  always_ff @(posedge clk) begin
    if (shift_en) chain_q <= chain_d;
  end

  assign q_o   = chain_q;
  assign top_o = chain_q[LEN-1];
endmodule

// File: rtl/dbl_pwm.sv
`timescale 1ns/1ps
module dbl_pwm #(
  parameter int NUM_CH = 24,
  parameter int W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH*W-1:0] duty_i,
  output logic [NUM_CH-1:0]   pwm_o
);
  logic [W-1:0]      cnt_q, cnt_d;
  logic [NUM_CH-1:0] pwm_q, pwm_d;

  assign cnt_d = cnt_q + 1'b1;

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_cmp
      assign pwm_d[n] = (cnt_q < duty_i[n*W +: W]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/dualbank_led_drv.sv
`timescale 1ns/1ps
module dualbank_led_drv
  import dbl_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CORR_W = 6,
  parameter int GRAY_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  input  logic              bank_sel_i,
  input  logic              load_n_i,
  input  logic              drv_run_i,
  input  logic              blank_i,
  output logic              ser_out_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int PROD_W = CORR_W + GRAY_W;
  localparam int A_LEN  = NUM_CH * CORR_W;
  localparam int B_LEN  = NUM_CH * GRAY_W;

  // ---------------- input synchronization ----------------
  logic [PIN_CNT-1:0]  pin_raw, pin_lvl;
  logic [EDGE_CNT-1:0] e_rise, e_fall;

  always_comb begin
    pin_raw            = '0;
    pin_raw[PIN_DATA]  = ser_data_i;
    pin_raw[PIN_BSEL]  = bank_sel_i;
    pin_raw[PIN_SCLK]  = ser_clk_i;
    pin_raw[PIN_LOAD]  = load_n_i;
    pin_raw[PIN_RUN]   = drv_run_i;
    pin_raw[PIN_BLANK] = blank_i;
  end

  dbl_sync_stage #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_raw), .lvl_o(pin_lvl)
  );

  dbl_edge_track #(.W(EDGE_CNT), .RST_VAL(PIN_RST[PIN_CNT-1:EDGE_BASE])) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(pin_lvl[PIN_CNT-1:EDGE_BASE]),
    .rise_o(e_rise), .fall_o(e_fall)
  );

  logic unused_edges;
  assign unused_edges = e_fall[EG_SCLK] & e_rise[EG_LOAD];

  // ---------------- shift chains ----------------
  logic             sh_a_ev, sh_b_ev;
  logic [A_LEN-1:0] bank_a_q;
  logic [B_LEN-1:0] bank_b_q;
  logic             top_a, top_b;

  assign sh_a_ev = e_rise[EG_SCLK] & ~pin_lvl[PIN_BSEL];
  assign sh_b_ev = e_rise[EG_SCLK] &  pin_lvl[PIN_BSEL];

  dbl_shift_chain #(.LEN(A_LEN)) u_bank_a (
    .clk(clk), .shift_en(sh_a_ev), .din(pin_lvl[PIN_DATA]),
    .q_o(bank_a_q), .top_o(top_a)
  );

  dbl_shift_chain #(.LEN(B_LEN)) u_bank_b (
    .clk(clk), .shift_en(sh_b_ev), .din(pin_lvl[PIN_DATA]),
    .q_o(bank_b_q), .top_o(top_b)
  );

  // ---------------- cascade output ----------------
  logic sout_q, sout_d;

  always_comb begin
    sout_d = sout_q;
    if (sh_a_ev)      sout_d = top_a;
    else if (sh_b_ev) sout_d = top_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sout_q <= 1'b0;
    else        sout_q <= sout_d;
  end

  assign ser_out_o = sout_q;

  // ---------------- product store and output gating ----------------
  logic                     latch_ev, latch_done_q;
  logic                     gate_on, eval_ev;
  logic [NUM_CH*PROD_W-1:0] lat_flat, out_flat;

  assign latch_ev = e_fall[EG_LOAD];
  assign gate_on  = pin_lvl[PIN_RUN] & ~pin_lvl[PIN_BLANK];
  assign eval_ev  = e_rise[EG_RUN] | e_fall[EG_RUN] |
                    e_rise[EG_BLANK] | e_fall[EG_BLANK] | latch_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_done_q <= 1'b0;
    else        latch_done_q <= latch_ev;
  end

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic [PROD_W-1:0] prod_d, lat_q, out_q, out_d;

      assign prod_d = PROD_W'(bank_a_q[n*CORR_W +: CORR_W]) *
                      PROD_W'(bank_b_q[n*GRAY_W +: GRAY_W]);

      // stored intensities survive reset: no reset term
      always_ff @(posedge clk) begin
        if (latch_ev) lat_q <= prod_d;
      end

      always_comb begin
        out_d = out_q;
        if (eval_ev) out_d = gate_on ? lat_q : '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
      end

      assign lat_flat[n*PROD_W +: PROD_W] = lat_q;
      assign out_flat[n*PROD_W +: PROD_W] = out_q;
    end
  endgenerate

  // ---------------- modulation ----------------
  dbl_pwm #(.NUM_CH(NUM_CH), .W(PROD_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty_i(out_flat), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/dualbank_led_drv_chk.sv
`timescale 1ns/1ps
module dualbank_led_drv_chk #(
  parameter int NUM_CH = 24,
  parameter int CORR_W = 6,
  parameter int GRAY_W = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              sh_a_ev,
  input logic                              sh_b_ev,
  input logic [NUM_CH*CORR_W-1:0]          bank_a,
  input logic [NUM_CH*GRAY_W-1:0]          bank_b,
  input logic                              ser_out,
  input logic                              latch_ev,
  input logic [NUM_CH*(CORR_W+GRAY_W)-1:0] lat_flat,
  input logic                              eval_ev,
  input logic                              gate_on,
  input logic [NUM_CH*(CORR_W+GRAY_W)-1:0] out_flat,
  input logic [NUM_CH-1:0]                 pwm
);
  localparam int A_TOP = NUM_CH*CORR_W - 1;
  localparam int B_TOP = NUM_CH*GRAY_W - 1;

  assert_hold_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_a_ev |=> $stable(bank_a));
  assert_hold_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_b_ev |=> $stable(bank_b));
  assert_one_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_a_ev, sh_b_ev}));
  assert_sout_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_a_ev |=> ser_out == $past(bank_a[A_TOP]));
  assert_sout_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_b_ev |=> ser_out == $past(bank_b[B_TOP]));
  assert_lat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_ev |=> $stable(lat_flat));
  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_ev && !gate_on) |=> (out_flat == '0));
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_ev |=> $stable(out_flat));
  assert_zero_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_flat == '0) |=> (pwm == '0));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_dark_R7: assert (pwm == '0);
    end
  end
endmodule

bind dualbank_led_drv dualbank_led_drv_chk #(
  .NUM_CH(NUM_CH), .CORR_W(CORR_W), .GRAY_W(GRAY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sh_a_ev(sh_a_ev), .sh_b_ev(sh_b_ev),
  .bank_a(bank_a_q), .bank_b(bank_b_q), .ser_out(ser_out_o),
  .latch_ev(latch_ev), .lat_flat(lat_flat), .eval_ev(eval_ev),
  .gate_on(gate_on), .out_flat(out_flat), .pwm(pwm_o)
);

// File: tb/dualbank_led_drv_bench.sv
`timescale 1ns/1ps
module dualbank_led_drv_bench;
  localparam int NCH  = 24;
  localparam int CW   = 6;
  localparam int GW   = 8;
  localparam int ALEN = NCH*CW;
  localparam int BLEN = NCH*GW;
  localparam int PER  = 16384;
  localparam int GAP  = 4;

  // {interleave, corr_base, corr_step, gray_base, gray_step}
  localparam logic [32:0] VEC [3] = '{
    {1'b0, 8'd60, 8'd1, 8'd0,   8'd0},
    {1'b0, 8'd63, 8'd0, 8'd255, 8'd0},
    {1'b1, 8'd5,  8'd7, 8'd3,   8'd11}
  };

  logic clk = 1'b0;
  logic rst_n, ser_data, ser_clk, bank_sel, load_n, run, blank;
  logic ser_out;
  logic [NCH-1:0] pwm;

  always #5 clk = ~clk;

  dualbank_led_drv u_dualbank_led_drv (
    .clk(clk), .rst_n(rst_n), .ser_data_i(ser_data), .ser_clk_i(ser_clk),
    .bank_sel_i(bank_sel), .load_n_i(load_n), .drv_run_i(run),
    .blank_i(blank), .ser_out_o(ser_out), .pwm_o(pwm)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  bit [ALEN-1:0] ma;
  bit [BLEN-1:0] mb;
  int exp_lat [NCH];

  task automatic check(input string req, input int got, input int expv);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic wait_clks(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // one serial bit; reports cascade output after the rising edge
  task automatic drive_bit(input bit sel, input bit b, output bit got, output bit expv);
    @(negedge clk);
    ser_data = b; bank_sel = sel;
    wait_clks(GAP);
    ser_clk = 1'b1;
    expv = sel ? mb[BLEN-1] : ma[ALEN-1];
    if (sel) mb = {mb[BLEN-2:0], b};
    else     ma = {ma[ALEN-2:0], b};
    wait_clks(GAP);
    got = ser_out;
    ser_clk = 1'b0;
    wait_clks(GAP);
  endtask

  task automatic load_vec(input logic [32:0] v);
    bit [ALEN-1:0] ta;
    bit [BLEN-1:0] tb;
    int ia, ib;
    bit turn, pick_a, g, e;
    for (int n = 0; n < NCH; n++) begin
      ta[n*CW +: CW] = 6'((v[31:24] + v[23:16]*n) & 63);
      tb[n*GW +: GW] = 8'((v[15:8] + v[7:0]*n) & 255);
    end
    ia = ALEN-1; ib = BLEN-1; turn = 0;
    while (ia >= 0 || ib >= 0) begin
      if (ia < 0)      pick_a = 0;
      else if (ib < 0) pick_a = 1;
      else if (v[32])  pick_a = !turn;
      else             pick_a = 1;
      turn = !turn;
      if (pick_a) begin drive_bit(1'b0, ta[ia], g, e); ia--; end
      else        begin drive_bit(1'b1, tb[ib], g, e); ib--; end
    end
  endtask

  function automatic int model_prod(input int n);
    return int'(ma[n*CW +: CW]) * int'(mb[n*GW +: GW]);
  endfunction

  task automatic pulse_load();
    @(negedge clk);
    load_n = 1'b0;
    for (int n = 0; n < NCH; n++) exp_lat[n] = model_prod(n);
    wait_clks(6);
    load_n = 1'b1;
    wait_clks(6);
  endtask

  // count high cycles of every channel over one counter period
  task automatic measure(input string req, input bit on);
    int cnt [NCH];
    for (int n = 0; n < NCH; n++) cnt[n] = 0;
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      for (int n = 0; n < NCH; n++) if (pwm[n]) cnt[n]++;
    end
    for (int n = 0; n < NCH; n++) check(req, cnt[n], on ? exp_lat[n] : 0);
  endtask

  initial begin
    #1_990_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit g, e;
    rst_n = 1'b1; ser_data = 0; ser_clk = 0; bank_sel = 0;
    load_n = 1'b1; run = 1'b1; blank = 1'b0;
    #2 rst_n = 1'b0;
    wait_clks(4);
    check("R7 reset pwm", int'(pwm), 0);
    check("R7 reset sout", int'(ser_out), 0);
    @(negedge clk) rst_n = 1'b1;
    wait_clks(8);

    // table walk: R1 R2 R4 R8 R9
    for (int t = 0; t < 3; t++) begin
      load_vec(VEC[t]);
      pulse_load();
      measure(t == 2 ? "R9 interleaved duty" : "R1 R4 R8 duty", 1'b1);
    end

    // R5: blank forces zero
    @(negedge clk) blank = 1'b1;
    wait_clks(8);
    measure("R5 blanked", 1'b0);
    @(negedge clk) blank = 1'b0;
    wait_clks(8);

    // R7: reset keeps stored intensities; run re-enables after release (R6)
    @(negedge clk) rst_n = 1'b0;
    wait_clks(3);
    check("R7 pwm low in reset", int'(pwm), 0);
    @(negedge clk) rst_n = 1'b1;
    wait_clks(8);
    measure("R7 R6 kept after reset", 1'b1);

    // R3 cascade bits, chains kept across reset (R7)
    for (int k = 0; k < 3; k++) begin
      drive_bit(1'b1, k[0], g, e);
      check("R3 R7 sout brightness chain", int'(g), int'(e));
      drive_bit(1'b0, !k[0], g, e);
      check("R3 R7 sout correction chain", int'(g), int'(e));
    end

    // R4: store on fall only, not on rise
    @(negedge clk) load_n = 1'b0;
    for (int n = 0; n < NCH; n++) exp_lat[n] = model_prod(n);
    wait_clks(8);
    for (int k = 0; k < 8; k++) begin
      drive_bit(1'b1, 1'b1, g, e);
      drive_bit(1'b0, 1'b1, g, e);
    end
    @(negedge clk) load_n = 1'b1;
    wait_clks(8);
    measure("R4 no store on rise", 1'b1);

    // R5: run low forces zero
    @(negedge clk) run = 1'b0;
    wait_clks(8);
    measure("R5 run low", 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule